// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block turns the system clock into the timing skeleton of a raster video frame. A divider counts system clocks into horizontal line periods and emits a one-clock line tick at the end of each period. A line counter advances on every tick and wraps at the end of the frame. A two-state machine drives the vertical-blank level from a line partway through the frame until the wrap. The wrap itself raises a one-clock frame interrupt. A second counter, separate from the line counter, counts line ticks and emits a one-clock strobe at a fixed line interval for an audio engine.

A one-bit standard select chooses between 60 Hz / 262-line timing and 50 Hz / 312-line timing. The line period for each standard is computed at elaboration from the system clock frequency parameter. The select is sampled only at the frame wrap, so a frame always completes with the timing it started with. The frame state machine has two states, `ST_ACTIVE` and `ST_BLANK`. The transition "enter blank" moves from `ST_ACTIVE` to `ST_BLANK` on the tick that brings the line number to the blank-start line. The transition "frame wrap" moves from `ST_BLANK` to `ST_ACTIVE` on the tick that follows the last line. On that same tick the line number returns to zero, the interrupt pulses and the new standard is loaded.

Top module: `vid_line_frame_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, line tick, frame interrupt and audio strobe are low, vblank is low and the line number is 0. The active standard after reset is 60 Hz.
- R2: The line tick is a one-clock pulse repeating every LP cycles, where LP = floor(SYS_CLK_HZ / (rate × lines)) of the active standard. The first tick appears LP cycles after reset is released.
- R3: The line number rises by one in the cycle after each line tick. After the last line (261 for 60 Hz, 311 for 50 Hz) it returns to 0, so a frame holds 262 or 312 ticks.
- R4: Vblank rises in the cycle in which the line number becomes 240 (60 Hz) or 256 (50 Hz). It stays high until the frame wrap.
- R5: The frame interrupt is a one-clock pulse in the cycle in which the line number returns to 0. Vblank falls in that same cycle.
- R6: The audio strobe is a one-clock pulse in the cycle after every 23rd line tick (60 Hz) or 22nd line tick (50 Hz). Its counter runs across frame wraps without being cleared.
- R7: The standard select encodes 0 as 60 Hz / 262 lines and 1 as 50 Hz / 312 lines. It is sampled only on the frame-wrap tick. A change in mid-frame has no effect on the current frame's length, blank line, line period or audio interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz / 262 lines, 1 = 50 Hz / 312 lines |
| line_tick_o | output | 1 | One-clock pulse at the end of each line period |
| vblank_o | output | 1 | Vertical-blank level |
| frame_irq_o | output | 1 | One-clock frame interrupt at the line wrap |
| audio_stb_o | output | 1 | One-clock audio-update strobe |
| line_num_o | output | LINE_W (9) | Current line number |

## Verification
After reset is released, the line tick is due exactly LP cycles later, and again every LP cycles after that. The line number, vblank, frame interrupt and audio strobe are all registered from the tick, so each is due one cycle after the tick that causes it. The bench drives and samples only at falling edges. At every falling edge it advances a running expectation from the requirements, one cycle of latency for the derived outputs and a cycle count for the tick, and compares all five outputs against it. Per-frame counts of ticks, blank cycles and strobes, taken at each interrupt, then check frame lengths across switches of the standard made in mid-frame.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } vstd_e;

    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_BLANK  = 1'b1
    } fstate_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vid_line_timer.sv
module vid_line_timer
    import vid_seq_pkg::*;
#(
    parameter int PERIOD_A = 9,
    parameter int PERIOD_B = 10,
    localparam int PER_W   = $clog2(max2(PERIOD_A, PERIOD_B) + 1)
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  vstd_e std_i,
    output logic  tick_o
);

    localparam logic [PER_W-1:0] LAST_A = PER_W'(PERIOD_A - 1);
    localparam logic [PER_W-1:0] LAST_B = PER_W'(PERIOD_B - 1);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last_sel;
    logic             tick_q;

    always_comb begin
        last_sel = (std_i == STD_50) ? LAST_B : LAST_A;
    end

    // the compare uses >= so that a shorter period loaded at a frame wrap can never be overrun
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= last_sel) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R2
    tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q);

endmodule

// File: rtl/vid_frame_fsm.sv
module vid_frame_fsm
    import vid_seq_pkg::*;
#(
    parameter int TOTAL_A  = 262,
    parameter int TOTAL_B  = 312,
    parameter int VBSTRT_A = 240,
    parameter int VBSTRT_B = 256,
    localparam int LINE_W  = $clog2(max2(TOTAL_A, TOTAL_B))
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  vstd_e             std_sel_i,
    output vstd_e             act_std_o,
    output logic              vblank_o,
    output logic              irq_o,
    output logic [LINE_W-1:0] line_o
);

    localparam logic [LINE_W-1:0] LAST_A = LINE_W'(TOTAL_A - 1);
    localparam logic [LINE_W-1:0] LAST_B = LINE_W'(TOTAL_B - 1);
    localparam logic [LINE_W-1:0] VB_A   = LINE_W'(VBSTRT_A);
    localparam logic [LINE_W-1:0] VB_B   = LINE_W'(VBSTRT_B);

    fstate_e           state_q, state_d;
    vstd_e             act_q;
    logic [LINE_W-1:0] line_q;
    logic              irq_q;
    logic [LINE_W-1:0] last_sel, vb_sel;
    logic              at_last, at_vbm1;

    always_comb begin
        last_sel = (act_q == STD_50) ? LAST_B : LAST_A;
        vb_sel   = (act_q == STD_50) ? VB_B : VB_A;
        at_last  = (line_q == last_sel);
        at_vbm1  = ((line_q + 1'b1) == vb_sel);
    end

    // next state: enter blank / frame wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (tick_i && at_vbm1) state_d = ST_BLANK;
            ST_BLANK:  if (tick_i && at_last) state_d = ST_ACTIVE;
            default:   state_d = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ACTIVE;
        else         state_q <= state_d;
    end

    // outputs: line number, interrupt, standard latched at the wrap
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q <= '0;
            irq_q  <= 1'b0;
            act_q  <= STD_60;
        end else begin
            irq_q <= 1'b0;
            if (tick_i) begin
                if (at_last) begin
                    line_q <= '0;
                    irq_q  <= 1'b1;
                    act_q  <= std_sel_i;
                end else begin
                    line_q <= line_q + 1'b1;
                end
            end
        end
    end

    assign vblank_o  = (state_q == ST_BLANK);
    assign irq_o     = irq_q;
    assign line_o    = line_q;
    assign act_std_o = act_q;

    // R3
    line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (line_q == '0) || (line_q == $past(line_q) + LINE_W'(1)));

    // R3
    line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(line_q));

    // R4
    blank_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q == ST_BLANK) |-> (line_q == vb_sel));

    // R5
    irq_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |-> (line_q == '0) && (state_q == ST_ACTIVE));

    // R5
    irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |=> !irq_q);

    // R7
    std_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_q |-> $stable(act_q));

endmodule

// File: rtl/vid_audio_strobe.sv
module vid_audio_strobe
    import vid_seq_pkg::*;
#(
    parameter int EVERY_A = 23,
    parameter int EVERY_B = 22,
    localparam int AUD_W  = $clog2(max2(EVERY_A, EVERY_B) + 1)
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  tick_i,
    input  vstd_e std_i,
    output logic  stb_o
);

    localparam logic [AUD_W-1:0] LAST_A = AUD_W'(EVERY_A - 1);
    localparam logic [AUD_W-1:0] LAST_B = AUD_W'(EVERY_B - 1);

    logic [AUD_W-1:0] cnt_q;
    logic [AUD_W-1:0] last_sel;
    logic             stb_q;

    always_comb begin
        last_sel = (std_i == STD_50) ? LAST_B : LAST_A;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (tick_i) begin
                if (cnt_q >= last_sel) begin
                    cnt_q <= '0;
                    stb_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign stb_o = stb_q;

    // R6
    aud_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_q |-> $past(tick_i));

    // R6
    aud_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_q |=> !stb_q);

endmodule

// File: rtl/vid_line_frame_seq.sv
module vid_line_frame_seq
    import vid_seq_pkg::*;
#(
    parameter int SYS_CLK_HZ = 33_868_800,
    parameter int RATE_60    = 60,
    parameter int RATE_50    = 50,
    parameter int LINES_60   = 262,
    parameter int LINES_50   = 312,
    parameter int VBLINE_60  = 240,
    parameter int VBLINE_50  = 256,
    parameter int AUDIV_60   = 23,
    parameter int AUDIV_50   = 22,
    localparam int LINE_W    = $clog2(max2(LINES_60, LINES_50))
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              std_sel_i,
    output logic              line_tick_o,
    output logic              vblank_o,
    output logic              frame_irq_o,
    output logic              audio_stb_o,
    output logic [LINE_W-1:0] line_num_o
);

    localparam int PERIOD_60 = SYS_CLK_HZ / (RATE_60 * LINES_60);
    localparam int PERIOD_50 = SYS_CLK_HZ / (RATE_50 * LINES_50);

    vstd_e act_std;
    logic  tick;

    vid_line_timer #(
        .PERIOD_A (PERIOD_60),
        .PERIOD_B (PERIOD_50)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .std_i  (act_std),
        .tick_o (tick)
    );

    vid_frame_fsm #(
        .TOTAL_A  (LINES_60),
        .TOTAL_B  (LINES_50),
        .VBSTRT_A (VBLINE_60),
        .VBSTRT_B (VBLINE_50)
    ) u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .std_sel_i (vstd_e'(std_sel_i)),
        .act_std_o (act_std),
        .vblank_o  (vblank_o),
        .irq_o     (frame_irq_o),
        .line_o    (line_num_o)
    );

    vid_audio_strobe #(
        .EVERY_A (AUDIV_60),
        .EVERY_B (AUDIV_50)
    ) u_audio (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .std_i  (act_std),
        .stb_o  (audio_stb_o)
    );

    assign line_tick_o = tick;

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> !line_tick_o && !frame_irq_o && !audio_stb_o && !vblank_o);

endmodule

// File: tb/vid_line_frame_seq_bench.sv
module vid_line_frame_seq_bench;

    localparam int CLK_HZ = 156_000;
    localparam int LP60   = CLK_HZ / (60 * 262);
    localparam int LP50   = CLK_HZ / (50 * 312);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_sel = 1'b0;
    logic       line_tick, vblank, frame_irq, audio_stb;
    logic [8:0] line_num;

    always #4 clk = ~clk;

    vid_line_frame_seq #(.SYS_CLK_HZ(CLK_HZ)) u_vid_line_frame_seq (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .std_sel_i   (std_sel),
        .line_tick_o (line_tick),
        .vblank_o    (vblank),
        .frame_irq_o (frame_irq),
        .audio_stb_o (audio_stb),
        .line_num_o  (line_num)
    );

    int checks = 0;
    int failures = 0;

    // running expectation
    int m_k, m_line, m_aud;
    bit m_vb, m_act, m_prev_tick;
    // per-frame statistics from the outputs
    int s_ticks, s_blank, s_aud, s_since, s_gap, s_irqs;
    int f_ticks, f_blank, f_aud;

    function automatic int lp_of(bit s);   return s ? LP50 : LP60; endfunction
    function automatic int tot_of(bit s);  return s ? 312 : 262;   endfunction
    function automatic int vb_of(bit s);   return s ? 256 : 240;   endfunction
    function automatic int aud_of(bit s);  return s ? 22 : 23;     endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit e_tick, e_irq, e_aud;
        @(negedge clk);
        e_tick = 0; e_irq = 0; e_aud = 0;
        if (m_prev_tick) begin
            if (m_aud >= aud_of(m_act) - 1) begin m_aud = 0; e_aud = 1; end
            else m_aud++;
            if (m_line == tot_of(m_act) - 1) begin
                m_line = 0; e_irq = 1; m_vb = 0; m_act = std_sel;
            end else begin
                m_line++;
                if (m_line == vb_of(m_act)) m_vb = 1;
            end
        end
        m_k++;
        if (m_k == lp_of(m_act)) begin e_tick = 1; m_k = 0; end
        m_prev_tick = e_tick;
        chk("R2", "line_tick", int'(line_tick), int'(e_tick));
        chk("R3", "line_num", int'(line_num), m_line);
        chk("R4", "vblank", int'(vblank), int'(m_vb));
        chk("R5", "frame_irq", int'(frame_irq), int'(e_irq));
        chk("R6", "audio_stb", int'(audio_stb), int'(e_aud));
        // statistics
        s_since++;
        if (line_tick) begin s_ticks++; s_gap = s_since; s_since = 0; end
        if (vblank) s_blank++;
        if (audio_stb) s_aud++;
        if (frame_irq) begin
            f_ticks = s_ticks; f_blank = s_blank; f_aud = s_aud;
            s_ticks = 0; s_blank = 0; s_aud = 0; s_irqs++;
        end
    endtask

    task automatic run_until_irqs(int n);
        int target = s_irqs + n;
        while (s_irqs < target) step();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "tick in reset", int'(line_tick), 0);
        chk("R1", "vblank in reset", int'(vblank), 0);
        chk("R1", "irq in reset", int'(frame_irq), 0);
        chk("R1", "audio in reset", int'(audio_stb), 0);
        chk("R1", "line in reset", int'(line_num), 0);
        rst_n = 1'b1;
        m_k = 0; m_line = 0; m_aud = 0; m_vb = 0; m_act = 0; m_prev_tick = 0;
        s_ticks = 0; s_blank = 0; s_aud = 0; s_since = 0; s_gap = 0; s_irqs = 0;
        step();
        chk("R1", "line after release", int'(line_num), 0);
        chk("R1", "vblank after release", int'(vblank), 0);
    endtask

    task automatic t_frame60();
        run_until_irqs(1);
        chk("R3", "ticks in 60 Hz frame", f_ticks, 262);
        chk("R4", "blank cycles 60 Hz", f_blank, (262 - 240) * LP60);
        chk("R6", "strobes in first frame", f_aud, 262 / 23);
        chk("R2", "tick gap 60 Hz", s_gap, LP60);
    endtask

    task automatic t_switch_to50();
        repeat (700) step();
        std_sel = 1'b1;
        run_until_irqs(1);
        chk("R7", "frame after mid-frame switch keeps 262", f_ticks, 262);
        chk("R7", "blank kept at 60 Hz line", f_blank, (262 - 240) * LP60);
        run_until_irqs(1);
        chk("R7", "ticks in 50 Hz frame", f_ticks, 312);
        chk("R4", "blank cycles 50 Hz", f_blank, (312 - 256) * LP50);
        chk("R2", "tick gap 50 Hz", s_gap, LP50);
    endtask

    task automatic t_switch_to60();
        repeat (500) step();
        std_sel = 1'b0;
        run_until_irqs(1);
        chk("R7", "50 Hz frame kept after switch back", f_ticks, 312);
        run_until_irqs(1);
        chk("R7", "ticks after return to 60 Hz", f_ticks, 262);
        chk("R2", "tick gap back at 60 Hz", s_gap, LP60);
        repeat (30 * LP60) step();
    endtask

    initial begin
        t_reset();
        t_frame60();
        t_switch_to50();
        t_switch_to60();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule